// File: doc/BRIEF.md
# Serial Configuration Loader with Chain Forwarding

This block is the configuration-side controller of a programmable device that takes its configuration image from a serial bit stream. After reset it spends a fixed number of system-clock cycles clearing configuration storage. During this time it pulls a shared open-drain status line low. It then releases the line. If another device, or an external agent, still holds the line low, the block waits. Once the sensed level is high, it samples a three-bit mode input. In a serial mode it shifts in a length-prefixed image, one bit per rising edge of the configuration clock, and checks the image's CRC. A good image puts the block in a user state with `done` high. A bad image pulls the status line low until the next reset.

The configuration clock comes from one of two places. In master mode the block makes it by dividing the system clock. In slave mode it takes an external clock and synchronises it. Bits that arrive after the block's own image are passed to `dout`, so the next device in a chain can be loaded from the same stream.

States: CLEAR (storage wipe, line held low) goes to WAIT when the wipe count ends. WAIT goes to MODE once the sensed line is high. MODE goes to LEN for a serial mode, or to PARK otherwise. LEN goes to DATA after 32 bits, or straight to CRC when the length is zero. DATA goes to CRC after the last payload bit. CRC goes to USER on a match and to ERROR on a mismatch. USER, ERROR and PARK are left only by reset.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is low, and for CLR_CYCLES system-clock cycles after it is released, `stat_drive_low` is 1. During that time `done` is 0 and `dout` is 1. After that, `stat_drive_low` goes to 0.
- R2: The status line is controlled only through `stat_drive_low`, which is a pull-low enable. `stat_sense` is the sensed wired-AND level. `stat_drive_low` is never 1 while `done` is 1.
- R3: If `stat_sense` is low once clearing ends, the block stays in WAIT and `cclk_out` stays 0. The mode is sampled only after `stat_sense` is seen high.
- R4: Mode encodings are 3'b000 for master serial and 3'b111 for slave serial. Any other value parks the block. In PARK, `done` stays 0, `dout` stays 1, `stat_drive_low` stays 0 and `cclk_out` stays 0, whatever is applied on `din` and `cclk_in`.
- R5: In slave mode, `cclk_in` passes through a two-stage synchroniser, and `din` is sampled at each detected rising edge of `cclk_in`.
- R6: In master mode, `cclk_out` toggles every CCLK_DIV system-clock cycles, so its period is 2*CCLK_DIV cycles. `din` is sampled at each rising edge of `cclk_out`.
- R7: The image is a 32-bit payload length sent MSB first, then that many payload bits, then a 16-bit CRC sent MSB first. The CRC uses polynomial 0x1021, starts at 0xFFFF, has no reflection and no final XOR, and covers the length and the payload. A length of zero is valid.
- R8: On a CRC match, `done` goes to 1 and stays 1 until reset.
- R9: On a CRC mismatch, `stat_drive_low` goes to 1 and stays 1 until reset, with `done` held at 0.
- R10: `dout` is 1 in every state other than USER.
- R11: In USER, a bit sampled at one rising configuration-clock edge is driven on `dout` from that edge until the next rising edge. A downstream device therefore captures it one configuration-clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Configuration mode select |
| cclk_in | input | 1 | External configuration clock (slave mode) |
| cclk_out | output | 1 | Generated configuration clock (master mode) |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next device in the chain |
| stat_drive_low | output | 1 | Pull-low enable for the open-drain status line |
| stat_sense | input | 1 | Sensed level of the status line |
| done | output | 1 | Configuration complete, CRC good |

## Verification
The assertions assume that `stat_sense` behaves as a wired-AND that includes this block's own pull-low. The bench builds it as an external enable ANDed with the inverted `stat_drive_low`. They also assume that `mode_sel` is steady around the MODE state, so the bench sets it before releasing reset. The slave-mode checks assume that each `cclk_in` phase lasts several system clocks and that `din` changes only when `cclk_in` falls. The bench holds each phase for six cycles. In master mode it changes `din` only after a falling edge of `cclk_out`.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_CLEAR,
        ST_WAIT,
        ST_MODE,
        ST_LEN,
        ST_DATA,
        ST_CRC,
        ST_USER,
        ST_ERROR,
        ST_PARK
    } ld_state_t;

    localparam logic [2:0] MODE_MASTER = 3'b000;
    localparam logic [2:0] MODE_SLAVE  = 3'b111;

    localparam int LEN_BITS = 32;
    localparam int CRC_BITS = 16;
    localparam logic [CRC_BITS-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_BITS-1:0] CRC_SEED = 16'hFFFF;

    function automatic logic [CRC_BITS-1:0] crc_step(input logic [CRC_BITS-1:0] c,
                                                     input logic b);
        logic fb;
        fb = c[CRC_BITS-1] ^ b;
        return {c[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/cfg_clk_src.sv
module cfg_clk_src #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_master,
    input  logic en_slave,
    input  logic cclk_in,
    input  logic din,
    output logic cclk_out,
    output logic bit_stb,
    output logic bit_val
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_cnt;
    logic          cclk_q;
    logic [2:0]    csync;
    logic [1:0]    dsync;
    logic          m_rise;
    logic          s_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            cclk_q  <= 1'b0;
            csync   <= '0;
            dsync   <= '0;
        end else begin
            csync <= {csync[1:0], cclk_in};
            dsync <= {dsync[0], din};
            if (!en_master) begin
                div_cnt <= '0;
                cclk_q  <= 1'b0;
            end else if (div_cnt == CW'(DIV - 1)) begin
                div_cnt <= '0;
                cclk_q  <= ~cclk_q;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign m_rise   = en_master && (div_cnt == CW'(DIV - 1)) && !cclk_q;
    assign s_rise   = en_slave && csync[1] && !csync[2];
    assign bit_stb  = m_rise || s_rise;
    assign bit_val  = en_master ? din : dsync[1];
    assign cclk_out = cclk_q;

endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16
    import cfg_loader_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                upd,
    input  logic                bit_in,
    output logic [CRC_BITS-1:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= CRC_SEED;
        else if (clr)
            crc <= CRC_SEED;
        else if (upd)
            crc <= crc_step(crc, bit_in);
    end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLR_CYCLES = 64,
    parameter int CCLK_DIV   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       cclk_in,
    output logic       cclk_out,
    input  logic       din,
    output logic       dout,
    output logic       stat_drive_low,
    input  logic       stat_sense,
    output logic       done
);
    localparam int CLR_W = $clog2(CLR_CYCLES + 1);
    localparam int CNT_W = $clog2(LEN_BITS);

    ld_state_t             state, nxt;
    logic [2:0]            mode_q;
    logic [CLR_W-1:0]      clr_cnt;
    logic [CNT_W-1:0]      bit_cnt;
    logic [LEN_BITS-1:0]   len_sh;
    logic [LEN_BITS-1:0]   len_left;
    logic [CRC_BITS-1:0]   crc_sh;
    logic [CRC_BITS-1:0]   crc_calc;
    logic                  dout_q;
    logic                  loading;
    logic                  en_master;
    logic                  en_slave;
    logic                  bit_stb;
    logic                  bit_val;
    logic [LEN_BITS-1:0]   len_next;
    logic [CRC_BITS-1:0]   crc_next;

    assign loading   = (state == ST_LEN) || (state == ST_DATA) ||
                       (state == ST_CRC) || (state == ST_USER);
    assign en_master = loading && (mode_q == MODE_MASTER);
    assign en_slave  = loading && (mode_q == MODE_SLAVE);
    assign len_next  = {len_sh[LEN_BITS-2:0], bit_val};
    assign crc_next  = {crc_sh[CRC_BITS-2:0], bit_val};

    cfg_clk_src #(.DIV(CCLK_DIV)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_master (en_master),
        .en_slave  (en_slave),
        .cclk_in   (cclk_in),
        .din       (din),
        .cclk_out  (cclk_out),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val)
    );

    cfg_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state == ST_MODE),
        .upd    (bit_stb && ((state == ST_LEN) || (state == ST_DATA))),
        .bit_in (bit_val),
        .crc    (crc_calc)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLEAR: if (clr_cnt == CLR_W'(CLR_CYCLES - 1)) nxt = ST_WAIT;
            ST_WAIT:  if (stat_sense) nxt = ST_MODE;
            ST_MODE:  nxt = ((mode_sel == MODE_MASTER) || (mode_sel == MODE_SLAVE))
                            ? ST_LEN : ST_PARK;
            ST_LEN:   if (bit_stb && (bit_cnt == CNT_W'(LEN_BITS - 1)))
                          nxt = (len_next == '0) ? ST_CRC : ST_DATA;
            ST_DATA:  if (bit_stb && (len_left == LEN_BITS'(1))) nxt = ST_CRC;
            ST_CRC:   if (bit_stb && (bit_cnt == CNT_W'(CRC_BITS - 1)))
                          nxt = (crc_next == crc_calc) ? ST_USER : ST_ERROR;
            ST_USER, ST_ERROR, ST_PARK: nxt = state;
            default:  nxt = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 3'b010;
            clr_cnt  <= '0;
            bit_cnt  <= '0;
            len_sh   <= '0;
            len_left <= '0;
            crc_sh   <= '0;
            dout_q   <= 1'b1;
        end else begin
            unique case (state)
                ST_CLEAR: clr_cnt <= clr_cnt + 1'b1;
                ST_MODE: begin
                    mode_q  <= mode_sel;
                    bit_cnt <= '0;
                end
                ST_LEN: if (bit_stb) begin
                    len_sh   <= len_next;
                    len_left <= len_next;
                    bit_cnt  <= bit_cnt + 1'b1;
                end
                ST_DATA: if (bit_stb) len_left <= len_left - 1'b1;
                ST_CRC: if (bit_stb) begin
                    crc_sh  <= crc_next;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_USER: if (bit_stb) dout_q <= bit_val;
                default: ;
            endcase
        end
    end

    always_comb begin
        stat_drive_low = (state == ST_CLEAR) || (state == ST_ERROR);
        done           = (state == ST_USER);
        dout           = (state == ST_USER) ? dout_q : 1'b1;
    end

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
    import cfg_loader_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input ld_state_t  state,
    input logic [2:0] mode_q,
    input logic       stat_sense,
    input logic       stat_drive_low,
    input logic       done,
    input logic       dout,
    input logic       cclk_out
);
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERROR) |=> ((state == ST_ERROR) && stat_drive_low && !done));

    // R10
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> dout);

    // R3
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT) && !stat_sense) |=> ((state == ST_WAIT) && !cclk_out));

    // R6
    mclk_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_out |-> (mode_q == MODE_MASTER));

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !stat_drive_low);
endmodule

bind serial_cfg_loader cfg_loader_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .mode_q         (mode_q),
    .stat_sense     (stat_sense),
    .stat_drive_low (stat_drive_low),
    .done           (done),
    .dout           (dout),
    .cclk_out       (cclk_out)
);

// File: tb/tb_serial_cfg_loader.sv
`timescale 1ns/1ps
module tb_serial_cfg_loader;
    localparam int CLR = 20;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b111;
    logic       cclk_in = 1'b0;
    logic       din = 1'b1;
    logic       ext_ok = 1'b1;
    logic       cclk_out, dout, stat_drive_low, stat_sense, done;
    int         checks = 0;
    int         errors = 0;
    logic       bits [0:127];
    int         nbits;

    assign stat_sense = ext_ok & ~stat_drive_low;

    always #2 clk = ~clk;

    serial_cfg_loader #(.CLR_CYCLES(CLR), .CCLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cclk_in(cclk_in),
        .cclk_out(cclk_out), .din(din), .dout(dout),
        .stat_drive_low(stat_drive_low), .stat_sense(stat_sense), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: reset and clearing phase
    task automatic do_reset(input logic [2:0] m, input logic ok);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; ext_ok = ok; cclk_in = 1'b0; din = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 drive_low in reset", stat_drive_low, 1);
        chk("R1 done in reset", done, 0);
        chk("R1 dout in reset", dout, 1);
        rst_n = 1'b1;
        repeat (CLR - 2) @(negedge clk);
        chk("R1 drive_low while clearing", stat_drive_low, 1);
        repeat (4) @(negedge clk);
        chk("R1 released after clearing", stat_drive_low, 0);
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        crc_upd = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // R7: image = length MSB-first, payload, CRC MSB-first
    task automatic build_image(input int len, input logic [31:0] pay, input logic bad);
        logic [15:0] c;
        logic [31:0] l;
        c = 16'hFFFF;
        l = 32'(len);
        nbits = 0;
        for (int i = 31; i >= 0; i--) begin
            bits[nbits] = l[i]; c = crc_upd(c, l[i]); nbits++;
        end
        for (int i = len - 1; i >= 0; i--) begin
            bits[nbits] = pay[i]; c = crc_upd(c, pay[i]); nbits++;
        end
        if (bad) c = c ^ 16'h0001;
        for (int i = 15; i >= 0; i--) begin
            bits[nbits] = c[i]; nbits++;
        end
    endtask

    task automatic slave_bit(input logic b);
        din = b; cclk_in = 1'b0;
        repeat (6) @(negedge clk);
        cclk_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // R5 R7 R10: slave load, dout high during own image
    task automatic send_slave_image;
        for (int i = 0; i < nbits; i++) begin
            slave_bit(bits[i]);
            if (i < nbits - 1) begin
                chk("R10 dout high while loading", dout, 1);
                chk("R8 done low while loading", done, 0);
            end
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_slave_good;
        logic [5:0] fwd;
        fwd = 6'b101100;
        do_reset(3'b111, 1'b1);
        build_image(8, 32'h000000A7, 1'b0);
        send_slave_image();
        chk("R8 done after good CRC (R5)", done, 1);
        chk("R2 line released when done", stat_drive_low, 0);
        chk("R10 dout high before forwarding", dout, 1);
        for (int i = 5; i >= 0; i--) begin
            slave_bit(fwd[i]);
            chk("R11 forwarded bit on dout", dout, fwd[i]);
        end
        chk("R8 done stays", done, 1);
    endtask

    task automatic t_slave_zero_len;
        do_reset(3'b111, 1'b1);
        build_image(0, 32'h0, 1'b0);
        send_slave_image();
        chk("R7 zero length image accepted", done, 1);
    endtask

    task automatic t_slave_bad;
        do_reset(3'b111, 1'b1);
        build_image(12, 32'h00000C35, 1'b1);
        send_slave_image();
        chk("R9 drive_low after bad CRC", stat_drive_low, 1);
        chk("R9 done low after bad CRC", done, 0);
        for (int i = 0; i < 3; i++) begin
            slave_bit(1'b0);
            chk("R10 dout high in error", dout, 1);
        end
        chk("R9 drive_low held", stat_drive_low, 1);
    endtask

    // R3 R6: stalled start, then master-mode load
    task automatic t_master_stall;
        time t0, t1;
        int  seen;
        do_reset(3'b000, 1'b0);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cclk_out) seen++;
        end
        chk("R3 no cclk while stalled", seen, 0);
        chk("R3 sensed line low while stalled", stat_sense, 0);
        build_image(5, 32'h00000013, 1'b0);
        din = bits[0];
        ext_ok = 1'b1;
        t0 = 0;
        for (int i = 0; i < nbits; i++) begin
            din = bits[i];
            @(posedge cclk_out);
            if (i == 0) t0 = $time;
            if (i == 1) begin
                t1 = $time;
                chk("R6 cclk period", 32'((t1 - t0) / 4), 2 * DIV);
            end
            @(negedge cclk_out);
        end
        @(negedge clk);
        chk("R6 master load done", done, 1);
        chk("R2 released in master done", stat_drive_low, 0);
    endtask

    // R4: non-serial mode parks
    task automatic t_park;
        int bad;
        do_reset(3'b010, 1'b1);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            slave_bit(1'(i % 3));
            if (done || !dout || stat_drive_low || cclk_out) bad++;
        end
        chk("R4 parked outputs unchanged", bad, 0);
        chk("R4 done low in park", done, 0);
    endtask

    initial begin
        t_slave_good();
        t_slave_zero_len();
        t_slave_bad();
        t_master_stall();
        t_park();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule